// File: doc/BRIEF.md
# Step Attenuator Control Interface

This block holds the 6-bit attenuation word of a digital step attenuator and decides where that word comes from. Each code step weighs 0.5 dB; bit 5 is the 16 dB step, bit 4 is 8 dB, bit 3 is 4 dB, bit 2 is 2 dB, bit 1 is 1 dB and bit 0 is 0.5 dB, so the 64 codes cover 0 to 31.5 dB. A mode input selects the source. In parallel mode the word comes from six control pins. In serial mode it comes from a shift register loaded by a data/clock pair. In both modes a latch-enable input opens the path to the output when high and freezes the output when low.

The serial clock, serial data and latch enable are asynchronous to the system clock. Each passes through a two-stage synchronizer, and a rising serial clock becomes a single shift pulse. Reset stands for power-up. At reset the output takes a default that depends on the mode: in serial mode, or in parallel mode with latch enable high, it copies the parallel pins. In parallel mode with latch enable low it is decoded from two select inputs. A one-cycle strobe marks every change of the output word.

Top module: `stepatt_ctrl`

## Requirements
- R1: ser_mode low makes the parallel pins the source of the output word. ser_mode high makes the shift register the source. The source that is not selected has no effect on the output.
- R2: Each rising edge of ser_clk shifts ser_data into the shift register exactly once, whatever the state of lat_en. The first bit shifted ends up in bit 5 (16 dB) after six edges and the last bit in bit 0 (0.5 dB).
- R3: In serial mode with lat_en high, atten_code follows the shift register contents.
- R4: While the synchronized lat_en is low, atten_code holds its value through serial shifting and through changes of par_code.
- R5: In parallel mode with lat_en held high, atten_code follows par_code.
- R6: In parallel mode, a high pulse on lat_en captures par_code as it stands at the falling edge, and that value is held afterwards.
- R7: At reset in serial mode, atten_code is loaded from par_code.
- R8: At reset in parallel mode with lat_en low, pup_sel (bit 1 is the MSB) sets atten_code: 00 gives 000000, 01 gives 010000 (8 dB), 10 gives 100000 (16 dB), 11 gives 111110 (31 dB).
- R9: At reset in parallel mode with lat_en high, pup_sel is ignored and atten_code is loaded from par_code.
- R10: code_chg is high for exactly those system clock cycles in which atten_code has just taken a new value. It is never high on a cycle where the value is unchanged, and it stays low through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial controls |
| rst_n | input | 1 | Synchronous active-low reset, models power-up |
| ser_mode | input | 1 | 0 = parallel source, 1 = serial source |
| par_code | input | 6 | Parallel attenuation word, bit 5 = 16 dB |
| ser_data | input | 1 | Serial data bit, MSB first |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| lat_en | input | 1 | Latch enable: high = transparent, low = hold |
| pup_sel | input | 2 | Power-up preset select for parallel mode |
| atten_code | output | 6 | Current attenuation word |
| code_chg | output | 1 | One-cycle pulse when atten_code changes |

## Verification
A corrupted shift register is not visible while lat_en is low. It shows up about three system cycles after lat_en rises, as a wrong atten_code that also raises a strobe. A wrong latch state, whether a missed hold or a missed capture, appears on atten_code in the cycle after the synchronized enable is sampled. A broken strobe shows as a code_chg pulse without a change, or as a change without a pulse, in that same cycle. Power-up faults appear in the first cycle after reset is released and persist until the latch next opens.

// File: rtl/stepatt_pkg.sv
// Shared widths, types and power-up decoding for the step attenuator control.
// Assumes a code word of at least 2 bits, LSB worth one half step.
package stepatt_pkg;
    localparam int CODE_W = 6;
    localparam int SEL_W  = 2;
    typedef logic [CODE_W-1:0] code_t;

    // Map the two preset select bits to a preset attenuation word.
    function automatic code_t preset_decode(input logic [SEL_W-1:0] sel);
        case (sel)
            2'b00:   return '0;
            2'b01:   return code_t'(1) << (CODE_W - 2);
            2'b10:   return code_t'(1) << (CODE_W - 1);
            default: return ~code_t'(1);
        endcase
    endfunction

    // Select the power-up word from mode, raw latch enable, pins and presets.
    function automatic code_t boot_word(input logic ser, input logic le,
                                        input code_t par, input logic [SEL_W-1:0] sel);
        if (ser || le) return par;
        return preset_decode(sel);
    endfunction
endpackage

// File: rtl/stepatt_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous control bits.
// Assumes the bits are quasi-static relative to STAGES system clock cycles.
module stepatt_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int CHAIN_W = W * STAGES;
    logic [CHAIN_W-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            // Single register stage.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= d;
            end
        end else begin : g_multi
            // Shift the bundle through STAGES registers.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[CHAIN_W-W-1:0], d};
            end
        end
    endgenerate

    assign q = chain[CHAIN_W-1 -: W];
endmodule

// File: rtl/stepatt_shifter.sv
// Serial-in parallel-out register. It shifts once per rising edge of the
// synchronized serial clock, and new bits enter at the LSB, so the first
// bit received ends up at the MSB. Assumes sclk_s and sdata_s come from
// the same synchronizer.
module stepatt_shifter
    import stepatt_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  code_t boot,
    input  logic  sclk_s,
    input  logic  sdata_s,
    output code_t sr
);
    logic sclk_d;
    logic shift_pulse;

    // Delay the synchronized clock by one cycle to detect its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_s;
    end

    assign shift_pulse = sclk_s & ~sclk_d;

    // Load the power-up word at reset; shift one bit in per edge pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)           sr <= boot;
        else if (shift_pulse) sr <= {sr[CODE_W-2:0], sdata_s};
    end

    assert_shift_once_R2: assert property (@(posedge clk) disable iff (!rst_n)
        shift_pulse |=> !shift_pulse);
    assert_shift_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        shift_pulse |=> (sr[0] == $past(sdata_s)) && (sr[CODE_W-1:1] == $past(sr[CODE_W-2:0])));
    assert_shift_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_pulse && $past(rst_n)) |=> $stable(sr));
endmodule

// File: rtl/stepatt_latch.sv
// Output latch for the attenuation word. While the synchronized enable is
// high it passes the source picked by the mode input; while it is low it
// holds. It also raises a one-cycle strobe whenever the word changes.
// Assumes the mode input and parallel pins are quasi-static.
module stepatt_latch
    import stepatt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  code_t                boot,
    input  logic                 ser_mode,
    input  logic                 le_raw,
    input  logic [SEL_W-1:0]     pup_sel,
    input  logic                 le_s,
    input  code_t                sr,
    input  code_t                par,
    output code_t                code_q,
    output logic                 chg_q
);
    code_t src;
    code_t code_d;

    // Pick the source word for the current mode.
    assign src    = ser_mode ? sr : par;
    // Pass the source when the latch is open, otherwise hold.
    assign code_d = le_s ? src : code_q;

    // Register the word and flag a change of value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= boot;
            chg_q  <= 1'b0;
        end else begin
            code_q <= code_d;
            chg_q  <= (code_d != code_q);
        end
    end

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !le_s) |=> $stable(code_q));
    assert_ser_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_mode && le_s) |=> code_q == $past(sr));
    assert_par_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_mode && le_s) |=> code_q == $past(par));
    assert_strobe_on_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && code_q != $past(code_q)) |-> chg_q);
    assert_strobe_only_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && chg_q) |-> code_q != $past(code_q));
    assert_boot_preset_R8: assert property (@(posedge clk)
        (rst_n === 1'b0 && ser_mode === 1'b0 && le_raw === 1'b0 && pup_sel === 2'b11)
        |=> code_q == ~code_t'(1));
    assert_boot_serial_R7: assert property (@(posedge clk)
        (rst_n === 1'b0 && ser_mode === 1'b1) |=> code_q == $past(par));
endmodule

// File: rtl/stepatt_ctrl.sv
// Top of the step attenuator control. It synchronizes the serial clock,
// serial data and latch enable, feeds the shift register and the output
// latch, and picks the power-up word from the raw pins while in reset.
// Assumes reset is held for at least one system clock edge.
module stepatt_ctrl
    import stepatt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_mode,
    input  logic [CODE_W-1:0] par_code,
    input  logic              ser_data,
    input  logic              ser_clk,
    input  logic              lat_en,
    input  logic [SEL_W-1:0]  pup_sel,
    output logic [CODE_W-1:0] atten_code,
    output logic              code_chg
);
    localparam int CTRL_W = 3;

    logic [CTRL_W-1:0] ctrl_s;
    code_t             boot;
    code_t             sr;

    // Power-up word, sampled by the registers only during reset.
    assign boot = boot_word(ser_mode, lat_en, par_code, pup_sel);

    stepatt_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ser_clk, ser_data, lat_en}),
        .q     (ctrl_s)
    );

    stepatt_shifter u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .boot    (boot),
        .sclk_s  (ctrl_s[2]),
        .sdata_s (ctrl_s[1]),
        .sr      (sr)
    );

    stepatt_latch u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .boot     (boot),
        .ser_mode (ser_mode),
        .le_raw   (lat_en),
        .pup_sel  (pup_sel),
        .le_s     (ctrl_s[0]),
        .sr       (sr),
        .par      (par_code),
        .code_q   (atten_code),
        .chg_q    (code_chg)
    );
endmodule

// File: tb/stepatt_ctrl_bench.sv
module stepatt_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_mode = 1'b0;
    logic [5:0] par_code = '0;
    logic       ser_data = 1'b0;
    logic       ser_clk = 1'b0;
    logic       lat_en = 1'b0;
    logic [1:0] pup_sel = '0;
    logic [5:0] atten_code;
    logic       code_chg;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    stepatt_ctrl u_stepatt_ctrl (
        .clk(clk), .rst_n(rst_n), .ser_mode(ser_mode), .par_code(par_code),
        .ser_data(ser_data), .ser_clk(ser_clk), .lat_en(lat_en),
        .pup_sel(pup_sel), .atten_code(atten_code), .code_chg(code_chg)
    );

    // Expected power-up word, from R7, R8, R9.
    function automatic logic [5:0] exp_boot(input logic ser, input logic le,
                                            input logic [5:0] par, input logic [1:0] sel);
        if (ser || le) return par;
        case (sel)
            2'b00:   return 6'b000000;
            2'b01:   return 6'b010000;
            2'b10:   return 6'b100000;
            default: return 6'b111110;
        endcase
    endfunction

    task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_boot(input string req, input logic ser, input logic le,
                           input logic [5:0] par, input logic [1:0] sel);
        rst_n = 1'b0; ser_mode = ser; lat_en = le; par_code = par; pup_sel = sel;
        ser_clk = 1'b0; ser_data = 1'b0;
        wait_n(3);
        chk({req, " code_chg low in reset"}, {5'b0, code_chg}, 6'b0);
        rst_n = 1'b1;
        wait_n(1);
        chk(req, atten_code, exp_boot(ser, le, par, sel));
        wait_n(6);
        chk(req, atten_code, exp_boot(ser, le, par, sel));
    endtask

    task automatic send_word(input logic [5:0] w);
        for (int i = 5; i >= 0; i--) begin
            ser_data = w[i]; ser_clk = 1'b0;
            wait_n(3);
            ser_clk = 1'b1;
            wait_n(3);
        end
        ser_clk = 1'b0;
        wait_n(3);
    endtask

    // R10 monitor: strobe must coincide exactly with a change of the word.
    logic [5:0] prev_code = '0;
    bit         prev_live = 1'b0;
    always @(negedge clk) begin
        if (rst_n && prev_live) begin
            if ((atten_code !== prev_code) || code_chg) begin
                n_cmp++;
                if (code_chg !== (atten_code !== prev_code)) begin
                    n_bad++;
                    $display("FAIL R10: actual code_chg %b expected %b", code_chg,
                             atten_code !== prev_code);
                end
            end
        end
        prev_code = atten_code;
        prev_live = rst_n;
    end

    initial begin
        logic [5:0] w, held, cap;
        logic [5:0] dir [3];
        void'($urandom(32'd20240611));
        dir[0] = 6'b100000; dir[1] = 6'b000001; dir[2] = 6'b101101;
        wait_n(2);
        // R8: every preset in parallel mode, latch enable low.
        for (int s = 0; s < 4; s++) do_boot("R8", 1'b0, 1'b0, 6'b101010, 2'(s));
        // R9: presets ignored when latch enable is high.
        do_boot("R9", 1'b0, 1'b1, 6'b010101, 2'b11);
        // R7: serial power-up takes the parallel pins.
        do_boot("R7", 1'b1, 1'b0, 6'b110011, 2'b01);
        for (int k = 0; k < 6; k++)
            do_boot("R7/R8/R9 random", 1'($urandom), 1'($urandom), 6'($urandom), 2'($urandom));

        // Serial words: directed then random.
        do_boot("R7", 1'b1, 1'b0, 6'b000000, 2'b00);
        held = 6'b000000;
        for (int k = 0; k < 10; k++) begin
            w = (k < 3) ? dir[k] : 6'($urandom);
            par_code = 6'($urandom);
            send_word(w);
            chk("R4 hold during shifting", atten_code, held);
            lat_en = 1'b1; wait_n(6);
            chk("R2/R3 serial word MSB first", atten_code, w);
            par_code = ~par_code; wait_n(4);
            chk("R1 parallel pins ignored in serial mode", atten_code, w);
            lat_en = 1'b0; wait_n(5);
            held = w;
            chk("R4 held after latch closes", atten_code, held);
        end
        // R2: shifting continues with the latch open.
        lat_en = 1'b1; wait_n(4);
        send_word(6'b011001); wait_n(2);
        chk("R2/R3 shift with latch open", atten_code, 6'b011001);
        lat_en = 1'b0; wait_n(4);

        // Parallel latched mode.
        ser_mode = 1'b0; wait_n(2);
        cap = 6'b011001;
        for (int k = 0; k < 10; k++) begin
            par_code = 6'($urandom); wait_n(4);
            chk("R4 parallel change with latch closed", atten_code, cap);
            cap = par_code;
            lat_en = 1'b1; wait_n(4); lat_en = 1'b0; wait_n(4);
            par_code = ~cap; wait_n(4);
            chk("R6 latched capture", atten_code, cap);
        end
        // R1: serial activity ignored in parallel mode.
        send_word(~cap);
        chk("R1 serial ignored in parallel mode", atten_code, cap);

        // Parallel direct mode.
        lat_en = 1'b1; wait_n(4);
        for (int k = 0; k < 12; k++) begin
            par_code = (k == 0) ? 6'b111111 : (k == 1) ? 6'b000000 : 6'($urandom);
            wait_n(2);
            chk("R5 direct follow", atten_code, par_code);
        end
        ser_data = 1'b1; ser_clk = 1'b1; wait_n(4); ser_clk = 1'b0; wait_n(4);
        chk("R1 serial ignored in direct mode", atten_code, par_code);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule